// File: doc/BRIEF.md
# Driver Impedance Calibration Scheduler

This block sits on the controller side of a DRAM interface. It decides when the PHY re-tunes its output driver impedance, and it follows each run through a request/done handshake. When the PHY reports that its start-up sequence has finished, the block requests one long calibration. After that it requests short calibrations at an interval that software programs. It issues a short calibration only in a cycle where the main command scheduler reports the command bus idle.

While a calibration is in flight, the block raises a busy flag, and the main scheduler must not issue other DRAM commands while it is high. A watchdog sizes its window from the kind of calibration in flight. If the done pulse does not arrive in time, the watchdog abandons the calibration and sets a sticky error flag. The block only chooses the command, times it and runs the handshake. Everything analog stays inside the PHY.

Top module: `zq_cal_sched`

## Requirements
- R1: From reset, `calReq`, `calBusy` and `calErr` are 0, and no request is issued while `phyInitDone` is 0.
- R2: The first request is the long kind (`calLong`=1). It appears on the cycle after the first clock edge that samples `phyInitDone` high.
- R3: `calReq` is a one-cycle pulse. `calBusy` rises together with it and falls on the cycle after the edge that samples `calDone` high.
- R4: A `calDone` pulse that arrives while `calBusy` is 0 has no effect: busy stays low and the timing of the next request is unchanged.
- R5: After a calibration completes, the interval counter is loaded with `intervalCfg`. With the bus idle, a short request (`calLong`=0) appears `intervalCfg`+1 cycles after the edge that sampled `calDone`.
- R6: `intervalCfg` is sampled only when a calibration completes. A change during a countdown affects only the next interval.
- R7: If the interval expires while `busIdle` is 0, the request stays pending. It is issued on the cycle after the first edge that samples `busIdle` high.
- R8: No request is issued while `calBusy` is high, and no short request is issued while `phyInitDone` is 0.
- R9: The watchdog covers a short calibration. If no done arrives, `calBusy` falls and `calErr` rises exactly 2×`SHORT_CYC` cycles after the request cycle. The interval then reloads as after a completion, and `calErr` stays high until reset.
- R10: The watchdog window for a long calibration is 2×`LONG_CYC` cycles, distinct from the short window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phyInitDone | input | 1 | PHY start-up sequence finished |
| busIdle | input | 1 | Command scheduler reports the bus idle this cycle |
| intervalCfg | input | INT_W | Cycles between a completion and the next short calibration |
| calDone | input | 1 | One-cycle completion pulse from the PHY |
| calReq | output | 1 | One-cycle calibration request to the PHY |
| calLong | output | 1 | Kind of the current calibration: 1 long, 0 short |
| calBusy | output | 1 | Calibration in flight; blocks other DRAM commands |
| calErr | output | 1 | Sticky watchdog timeout flag |

## Verification
The hardest conditions to reach from the ports are the deferred request and the two watchdog expiries. Neither occurs while the PHY and the bus behave well. The bench holds `busIdle` low across the moment the interval runs out, waits several more cycles, and then releases it so that the issue edge can be observed. It also withholds `calDone` for a short run and, after a fresh reset, for a long run. It counts busy cycles up to the exact release edge in each case.

// File: rtl/zqsch_pkg.sv
package zqsch_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_INIT = 2'd0,
    ST_LONG      = 2'd1,
    ST_IDLE      = 2'd2,
    ST_SHORT     = 2'd3
  } zqState_e;

  // Strobes from sequencer to timer datapath
  typedef struct packed {
    logic issue;      // a request is launched this cycle
    logic issueLong;  // the launched request is the long kind
    logic busyRun;    // a calibration is in flight
    logic idleRun;    // interval countdown is active
    logic reload;     // calibration finished or abandoned
  } zqStrobe_t;

endpackage

// File: rtl/zq_timer_dp.sv
module zq_timer_dp
  import zqsch_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int LONG_CYC  = 512,
  parameter int SHORT_CYC = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  zqStrobe_t        stb,
  input  logic [INT_W-1:0] intervalCfg,
  output logic             intExpired,
  output logic             wdExpired
);

  localparam int WD_W = $clog2(2 * LONG_CYC + 1);
  localparam logic [WD_W-1:0] LONG_LIM  = WD_W'(2 * LONG_CYC - 1);
  localparam logic [WD_W-1:0] SHORT_LIM = WD_W'(2 * SHORT_CYC - 1);

  logic [INT_W-1:0] intCnt;
  logic [WD_W-1:0]  wdCnt;
  logic             kindLong;
  logic [WD_W-1:0]  wdLimit;

  assign wdLimit    = kindLong ? LONG_LIM : SHORT_LIM;
  assign intExpired = (intCnt == '0);
  assign wdExpired  = stb.busyRun && (wdCnt == wdLimit);

  // Interval countdown: loaded on completion, frozen at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
    end else if (stb.reload) begin
      intCnt <= intervalCfg;
    end else if (stb.idleRun && !intExpired) begin
      intCnt <= intCnt - INT_W'(1);
    end
  end

  // Watchdog: cleared at launch, counts while in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt    <= '0;
      kindLong <= 1'b0;
    end else if (stb.issue) begin
      wdCnt    <= '0;
      kindLong <= stb.issueLong;
    end else if (stb.busyRun && !wdExpired) begin
      wdCnt <= wdCnt + WD_W'(1);
    end
  end

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.busyRun |-> (wdCnt <= wdLimit)); // R9

  AST_COUNT_FROZEN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busyRun && !stb.reload) |=> $stable(intCnt)); // R6

endmodule

// File: rtl/zq_seq_ctrl.sv
module zq_seq_ctrl
  import zqsch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      phyInitDone,
  input  logic      busIdle,
  input  logic      calDone,
  input  logic      intExpired,
  input  logic      wdExpired,
  output zqStrobe_t stb,
  output logic      calReq,
  output logic      calLong,
  output logic      calBusy,
  output logic      calErr
);

  zqState_e state;
  logic     pending;
  logic     inFlight;
  logic     startLong;
  logic     startShort;
  logic     finish;

  assign inFlight   = (state == ST_LONG) || (state == ST_SHORT);
  assign startLong  = (state == ST_WAIT_INIT) && phyInitDone;
  assign startShort = (state == ST_IDLE) && intExpired && busIdle && phyInitDone;
  assign finish     = inFlight && (calDone || wdExpired);

  always_comb begin
    stb           = '0;
    stb.issue     = startLong || startShort;
    stb.issueLong = startLong;
    stb.busyRun   = inFlight;
    stb.idleRun   = (state == ST_IDLE);
    stb.reload    = finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT_INIT;
      calReq  <= 1'b0;
      calLong <= 1'b0;
      calBusy <= 1'b0;
      calErr  <= 1'b0;
      pending <= 1'b0;
    end else begin
      calReq <= 1'b0;
      unique case (state)
        ST_WAIT_INIT: begin
          if (startLong) begin
            state   <= ST_LONG;
            calReq  <= 1'b1;
            calLong <= 1'b1;
            calBusy <= 1'b1;
          end
        end
        ST_LONG, ST_SHORT: begin
          if (calDone) begin
            state   <= ST_IDLE;
            calBusy <= 1'b0;
          end else if (wdExpired) begin
            state   <= ST_IDLE;
            calBusy <= 1'b0;
            calErr  <= 1'b1;
          end
        end
        ST_IDLE: begin
          if (startShort) begin
            state   <= ST_SHORT;
            calReq  <= 1'b1;
            calLong <= 1'b0;
            calBusy <= 1'b1;
            pending <= 1'b0;
          end else if (intExpired) begin
            pending <= 1'b1;
          end
        end
        default: state <= ST_WAIT_INIT;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    calReq |=> !calReq); // R3

  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    calReq |-> calBusy); // R3

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    calReq |-> !$past(calBusy)); // R8

  AST_REQ_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    calReq |-> $past(phyInitDone)); // R1

  AST_SHORT_ON_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (calReq && !calLong) |-> $past(busIdle)); // R7

  AST_PENDING_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pending && busIdle && phyInitDone) |=> calReq); // R7

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && calDone) |=> !calBusy); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    calErr |=> calErr); // R9

endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
  import zqsch_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int LONG_CYC  = 512,
  parameter int SHORT_CYC = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phyInitDone,
  input  logic             busIdle,
  input  logic [INT_W-1:0] intervalCfg,
  input  logic             calDone,
  output logic             calReq,
  output logic             calLong,
  output logic             calBusy,
  output logic             calErr
);

  zqStrobe_t stb;
  logic      intExpired;
  logic      wdExpired;

  zq_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phyInitDone(phyInitDone),
    .busIdle    (busIdle),
    .calDone    (calDone),
    .intExpired (intExpired),
    .wdExpired  (wdExpired),
    .stb        (stb),
    .calReq     (calReq),
    .calLong    (calLong),
    .calBusy    (calBusy),
    .calErr     (calErr)
  );

  zq_timer_dp #(
    .INT_W    (INT_W),
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .intervalCfg(intervalCfg),
    .intExpired (intExpired),
    .wdExpired  (wdExpired)
  );

endmodule

// File: tb/sim_zq_cal_sched.sv
module sim_zq_cal_sched;

  localparam int CLK_PERIOD = 10;
  localparam int INT_W      = 16;
  localparam int LONG_CYC   = 512;
  localparam int SHORT_CYC  = 64;

  logic             clk = 1'b0;
  logic             rstN;
  logic             phyInitDone;
  logic             busIdle;
  logic [INT_W-1:0] intervalCfg;
  logic             calDone;
  logic             calReq;
  logic             calLong;
  logic             calBusy;
  logic             calErr;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zq_cal_sched #(
    .INT_W(INT_W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .phyInitDone(phyInitDone), .busIdle(busIdle),
    .intervalCfg(intervalCfg), .calDone(calDone), .calReq(calReq),
    .calLong(calLong), .calBusy(calBusy), .calErr(calErr)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseDone();
    calDone = 1'b1;
    step();
    calDone = 1'b0;
  endtask

  // Steps until calReq is seen; returns step count (limit+1 if never)
  task automatic waitReq(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (calReq) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; phyInitDone = 1'b0; busIdle = 1'b1; calDone = 1'b0;
    intervalCfg = 16'd20;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  task automatic tResetAndLong();
    int sawReq = 0;
    doReset();
    check(!calReq && !calBusy && !calErr, "R1", "outputs after reset",
          {calReq, calBusy, calErr}, 0);
    for (int i = 0; i < 6; i++) begin
      step();
      if (calReq) sawReq++;
    end
    check(sawReq == 0, "R1", "requests without init done", sawReq, 0);
    phyInitDone = 1'b1;
    step();
    check(calReq && calLong && calBusy, "R2", "long request after init",
          {calReq, calLong, calBusy}, 7);
    step();
    check(!calReq && calBusy, "R3", "req pulse width / busy held",
          {calReq, calBusy}, 1);
    sawReq = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (calReq) sawReq++;
    end
    check(sawReq == 0, "R8", "request while busy", sawReq, 0);
    check(calBusy == 1'b1, "R3", "busy before done", calBusy, 1);
    pulseDone();
    check(calBusy == 1'b0, "R3", "busy after done", calBusy, 0);
  endtask

  task automatic tIntervalAndSpurious();
    int n;
    // continuing from completion with intervalCfg=20 loaded
    waitReq(60, n);
    check(n == 21, "R5", "short request delay", n, 21);
    check(calLong == 1'b0, "R5", "short kind", calLong, 0);
    // R6: change config during countdown
    intervalCfg = 16'd30;
    step();
    pulseDone();
    intervalCfg = 16'd5;
    waitReq(80, n);
    check(n == 31, "R6", "interval sampled at completion", n, 31);
    // R4: spurious done while idle
    step();
    pulseDone();            // real completion, loads 5
    step();
    pulseDone();            // stray done, 2 steps consumed
    check(calBusy == 1'b0, "R4", "busy after stray done", calBusy, 0);
    waitReq(40, n);
    check(n == 4, "R4", "request timing after stray done", n, 4);
  endtask

  task automatic tPending();
    int n;
    step();
    intervalCfg = 16'd8;
    pulseDone();
    busIdle = 1'b0;
    waitReq(20, n);
    check(n == 21, "R7", "request while bus busy", n, 21);
    busIdle = 1'b1;
    step();
    check(calReq && !calLong, "R7", "request at first idle", {calReq, calLong}, 2);
    // R8: init flag low at expiry blocks short request
    step();
    pulseDone();
    phyInitDone = 1'b0;
    waitReq(20, n);
    check(n == 21, "R8", "request without init done", n, 21);
    phyInitDone = 1'b1;
    step();
    check(calReq == 1'b1, "R8", "request after init restored", calReq, 1);
  endtask

  task automatic tShortTimeout();
    int n;
    int busyLen = 0;
    // request was seen at the current step; withhold done
    for (int k = 1; k <= 2 * SHORT_CYC; k++) begin
      step();
      if (calBusy) busyLen++;
      if (k == 2 * SHORT_CYC - 1)
        check(calErr == 1'b0, "R9", "err before window end", calErr, 0);
    end
    check(busyLen == 2 * SHORT_CYC - 1, "R9", "short busy length", busyLen,
          2 * SHORT_CYC - 1);
    check(calErr == 1'b1 && calBusy == 1'b0, "R9", "timeout flags",
          {calErr, calBusy}, 2);
    waitReq(20, n);
    check(n == 9, "R9", "reload after timeout", n, 9);
    check(calErr == 1'b1, "R9", "err sticky", calErr, 1);
  endtask

  task automatic tLongTimeout();
    doReset();
    phyInitDone = 1'b1;
    step();
    check(calReq && calLong, "R2", "long request after reset", {calReq, calLong}, 3);
    for (int k = 1; k <= 2 * LONG_CYC; k++) begin
      step();
      if (k == 2 * SHORT_CYC)
        check(calBusy == 1'b1, "R10", "long survives short window", calBusy, 1);
      if (k == 2 * LONG_CYC - 1)
        check(calBusy && !calErr, "R10", "busy before long window end",
              {calBusy, calErr}, 2);
    end
    check(!calBusy && calErr, "R10", "long timeout flags", {calBusy, calErr}, 1);
  endtask

  initial begin
    tResetAndLong();
    tIntervalAndSpurious();
    tPending();
    tShortTimeout();
    tLongTimeout();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule